// File: doc/BRIEF.md
# Twisted-Ring Background Generator and Read Checker

This block supplies the data words for a word-oriented memory self-test and judges the words read back. A twisted-ring (Johnson) register of `W` bits steps through `2*W` distinct background words, starting from all zeros, passing through all ones, and returning to all zeros. Stepping through every state, rather than only the few a minimal set would need, keeps the generator to one shift register. Applying many backgrounds exposes coupling faults between bits that share a word.

A march controller owns the sequencing. It pulses `restart_i` at the start of a test, pulses `bg_step_i` to advance to the next background, and holds `pol_inv_i` at the write polarity of the current march element. The write word is the background or its complement. In a march element, a read expects the complement of the word that the element writes. The checker therefore compares the read word against the complement of the write word. It does this with a bitwise XOR followed by an OR over all `W` bits. The resulting flag is qualified by `chk_en_i`. A sticky fail bit accumulates every qualified miscompare.

Top module: `march_bg_gen`

## Requirements
- R1: After reset the background is all zeros: with `pol_inv_i`=0, `wdata_o` is 0. `fail_o` and `bg_final_o` are 0.
- R2: A high `bg_step_i` at a clock edge shifts the background one place toward the MSB and loads the inverted old MSB into bit 0. Without `bg_step_i` or `restart_i`, the background holds its value.
- R3: Starting from all zeros, `2*W` steps visit `2*W` distinct words. Step `W` gives all ones, and step `2*W` gives all zeros again.
- R4: `bg_final_o` is 1 exactly when the background has bit `W-1` set and every other bit clear.
- R5: `wdata_o` equals the background when `pol_inv_i`=0 and its bitwise complement when `pol_inv_i`=1, in the same cycle.
- R6: While `chk_en_i`=1, `miscompare_o` is 1 in the same cycle exactly when `rdata_i` differs in any bit from the complement of `wdata_o`.
- R7: While `chk_en_i`=0, `miscompare_o` is 0 whatever `rdata_i` holds.
- R8: `fail_o` becomes 1 at the edge after a cycle with a qualified miscompare. It then stays 1 until a restart.
- R9: A high `restart_i` at an edge clears the background and `fail_o`. It takes priority over a step and over a miscompare in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart_i | input | 1 | Return to the first background and clear the fail bit |
| bg_step_i | input | 1 | Advance to the next background |
| pol_inv_i | input | 1 | Write polarity: 1 selects the complemented background |
| chk_en_i | input | 1 | Qualifies the read comparison this cycle |
| rdata_i | input | W | Word read from the memory under test |
| wdata_o | output | W | Word to write to the memory under test |
| miscompare_o | output | 1 | Qualified read miscompare, combinational |
| bg_final_o | output | 1 | Background is the last state before wrapping |
| fail_o | output | 1 | Sticky record of any qualified miscompare |

## Verification
A corrupted twisted-ring register shows at `wdata_o` in the same cycle. It usually also breaks the shift relation at the next step or moves the wrap point, so `bg_final_o` rises at the wrong count. A wrong polarity or comparison term shows at `miscompare_o` in the cycle the read is qualified. A sticky bit that clears or sets wrongly shows at `fail_o` one edge later. The bench checks every output against a model in every cycle of a randomized run, so each of these faults appears within a cycle or two of its cause.

// File: rtl/march_bg_pkg.sv
package march_bg_pkg;
  localparam int unsigned MBG_DEF_W = 8;

  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_INV  = 1'b1
  } mbg_pol_e;
endpackage

// File: rtl/march_bg_rst_sync.sv
module march_bg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/march_bg_ring.sv
module march_bg_ring #(
  parameter int unsigned W = march_bg_pkg::MBG_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         step_i,
  output logic [W-1:0] bg_o,
  output logic         final_o
);
  localparam logic [W-1:0] FINAL_WORD = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ring_q, ring_d;
  logic         ring_en;

  assign ring_en = restart_i | step_i;

  always_comb begin
    ring_d = ring_q;
    if (restart_i)   ring_d = '0;
    else if (step_i) ring_d = {ring_q[W-2:0], ~ring_q[W-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= '0;
    else if (ring_en) ring_q <= ring_d;
  end

  assign bg_o    = ring_q;
  assign final_o = (ring_q == FINAL_WORD);

  // R2: without a strobe the background holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !step_i) |=> $stable(bg_o));
  // R9: a restart leaves all zeros
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (bg_o == '0));
  // R3: stepping from the final word wraps to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (final_o && step_i && !restart_i) |=> (bg_o == '0));
  // R2: each step changes exactly one bit
  p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !restart_i) |=> ($countones(bg_o ^ $past(bg_o)) == 1));
endmodule

// File: rtl/march_bg_polarity.sv
module march_bg_polarity #(
  parameter int unsigned W = march_bg_pkg::MBG_DEF_W
) (
  input  logic         pol_inv_i,
  input  logic [W-1:0] bg_i,
  output logic [W-1:0] wdata_o,
  output logic [W-1:0] expect_o
);
  import march_bg_pkg::*;

  mbg_pol_e pol;
  assign pol = mbg_pol_e'(pol_inv_i);

  always_comb begin
    unique case (pol)
      POL_INV: wdata_o = ~bg_i;
      default: wdata_o = bg_i;
    endcase
    expect_o = ~wdata_o;
  end

  // R5: write word is the background or its complement
  always_comb begin
    a_pol_r5: assert ((wdata_o == bg_i) || (wdata_o == ~bg_i));
  end
endmodule

// File: rtl/march_bg_compare.sv
module march_bg_compare #(
  parameter int unsigned W = march_bg_pkg::MBG_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         chk_en_i,
  input  logic [W-1:0] rdata_i,
  input  logic [W-1:0] expect_i,
  output logic         miscompare_o,
  output logic         fail_o
);
  logic [W-1:0] diff;
  logic         any_diff;
  logic         fail_q, fail_d, fail_en;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign diff[b] = rdata_i[b] ^ expect_i[b];
  end

  assign any_diff     = |diff;
  assign miscompare_o = chk_en_i & any_diff;

  assign fail_en = restart_i | miscompare_o;

  always_comb begin
    fail_d = fail_q;
    if (restart_i)         fail_d = 1'b0;
    else if (miscompare_o) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fail_q <= 1'b0;
    else if (fail_en) fail_q <= fail_d;
  end

  assign fail_o = fail_q;

  // R7: no flag without the qualifier
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en_i |-> !miscompare_o);
  // R8: fail sets after a qualified miscompare
  p_fail_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (miscompare_o && !restart_i) |=> fail_o);
  // R8: fail is sticky until restart
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !restart_i) |=> fail_o);
  // R9: restart clears fail
  p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !fail_o);
endmodule

// File: rtl/march_bg_gen.sv
module march_bg_gen #(
  parameter int unsigned W = march_bg_pkg::MBG_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         bg_step_i,
  input  logic         pol_inv_i,
  input  logic         chk_en_i,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] wdata_o,
  output logic         miscompare_o,
  output logic         bg_final_o,
  output logic         fail_o
);
  logic         rst_sync_n;
  logic [W-1:0] bg;
  logic [W-1:0] expect_word;

  march_bg_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  march_bg_ring #(.W(W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart_i(restart_i),
    .step_i   (bg_step_i),
    .bg_o     (bg),
    .final_o  (bg_final_o)
  );

  march_bg_polarity #(.W(W)) u_pol (
    .pol_inv_i(pol_inv_i),
    .bg_i     (bg),
    .wdata_o  (wdata_o),
    .expect_o (expect_word)
  );

  march_bg_compare #(.W(W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .restart_i   (restart_i),
    .chk_en_i    (chk_en_i),
    .rdata_i     (rdata_i),
    .expect_i    (expect_word),
    .miscompare_o(miscompare_o),
    .fail_o      (fail_o)
  );

  // R6: with the qualifier high, a read equal to the complement of the write word never flags
  p_match_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_en_i && (rdata_i == ~wdata_o)) |-> !miscompare_o);
  // R4: the final flag needs the MSB set
  p_final_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bg_final_o |-> ((pol_inv_i ? ~wdata_o[W-1] : wdata_o[W-1]) == 1'b1));
endmodule

// File: tb/march_bg_gen_test.sv
module march_bg_gen_test;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         restart_i = 1'b0, bg_step_i = 1'b0, pol_inv_i = 1'b0, chk_en_i = 1'b0;
  logic [W-1:0] rdata_i = '0;
  logic [W-1:0] wdata_o;
  logic         miscompare_o, bg_final_o, fail_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_bg;
  logic         m_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  march_bg_gen #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .bg_step_i(bg_step_i),
    .pol_inv_i(pol_inv_i), .chk_en_i(chk_en_i), .rdata_i(rdata_i),
    .wdata_o(wdata_o), .miscompare_o(miscompare_o), .bg_final_o(bg_final_o),
    .fail_o(fail_o)
  );

  function automatic logic [W-1:0] f_next(input logic [W-1:0] q);
    return {q[W-2:0], ~q[W-1]};
  endfunction
  function automatic logic [W-1:0] f_wr(input logic [W-1:0] q, input logic inv);
    return inv ? ~q : q;
  endfunction
  function automatic logic f_mis(input logic [W-1:0] q, input logic inv,
                                 input logic [W-1:0] rd, input logic en);
    return en && (rd != ~f_wr(q, inv));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R5 wdata"}, wdata_o, f_wr(m_bg, pol_inv_i));
    chk({tag, " R6/R7 miscompare"}, W'(miscompare_o), W'(f_mis(m_bg, pol_inv_i, rdata_i, chk_en_i)));
    chk({tag, " R4 final"}, W'(bg_final_o), W'(m_bg == {1'b1, {(W-1){1'b0}}}));
    chk({tag, " R8 fail"}, W'(fail_o), W'(m_fail));
  endtask

  // one cycle: inputs already driven after a negedge; check, then clock and update model
  task automatic cycle(input string tag);
    #1;
    chk_all(tag);
    @(posedge clk);
    if (restart_i) begin m_bg = '0; m_fail = 1'b0; end
    else begin
      if (f_mis(m_bg, pol_inv_i, rdata_i, chk_en_i)) m_fail = 1'b1;
      if (bg_step_i) m_bg = f_next(m_bg);
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic rs, input logic st, input logic iv,
                       input logic en, input logic [W-1:0] rd);
    restart_i = rs; bg_step_i = st; pol_inv_i = iv; chk_en_i = en; rdata_i = rd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] seen [2*W];
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_bg = '0; m_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    drive(0, 0, 0, 0, '0);
    #1;
    chk("R1 wdata after reset", wdata_o, '0);
    chk("R1 fail after reset", W'(fail_o), '0);
    chk("R1 final after reset", W'(bg_final_o), '0);
    @(negedge clk);

    // R2/R3 full walk of 2W states
    for (int i = 0; i < 2*W; i++) begin
      drive(0, 0, 0, 0, '0);
      #1;
      seen[i] = wdata_o;
      if (i == W) chk("R3 all ones at step W", wdata_o, '1);
      for (int j = 0; j < i; j++)
        if (seen[j] == seen[i]) chk("R3 distinct words", seen[i], ~seen[i]);
      drive(0, 1, 0, 0, '0);
      cycle("R2 walk");
    end
    drive(0, 0, 0, 0, '0);
    #1;
    chk("R3 wrap to zero", wdata_o, '0);
    @(negedge clk);

    // R2 hold without a step
    drive(0, 1, 0, 0, '0); cycle("R2 step");
    drive(0, 0, 1, 0, '0); cycle("R2 hold");
    drive(0, 0, 0, 0, '0); #1; chk("R2 held value", wdata_o, 8'h01); @(negedge clk);

    // R7 unqualified bad read
    drive(0, 0, 0, 0, '1); cycle("R7 gate");
    chk("R7 no fail from unqualified read", W'(fail_o), '0);

    // R6/R8 qualified bad read, then sticky
    drive(0, 0, 1, 1, 8'h00); cycle("R6 bad read");
    drive(0, 0, 0, 0, '0); cycle("R8 sticky");
    chk("R8 fail stays set", W'(fail_o), 8'h01);

    // R9 restart beats step and miscompare
    drive(1, 1, 0, 1, '0); cycle("R9 restart");
    drive(0, 0, 0, 0, '0); #1;
    chk("R9 bg cleared", wdata_o, '0);
    chk("R9 fail cleared", W'(fail_o), '0);
    @(negedge clk);

    // random run
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] rd;
      logic iv;
      iv = 1'($urandom);
      rd = ~f_wr(m_bg, iv);
      if ($urandom_range(0, 9) == 0) rd = rd ^ W'(1 << $urandom_range(0, W-1));
      if ($urandom_range(0, 19) == 0) rd = W'($urandom);
      drive(($urandom_range(0, 39) == 0), 1'($urandom), iv, 1'($urandom), rd);
      cycle("random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule